// File: doc/BRIEF.md
# Dual-Mode Floating-Point Adder

This block adds floating-point numbers in one of two modes chosen for each operation. In single-precision mode it adds one pair of 32-bit operands with 1 sign, 8 exponent and 23 fraction bits. In half-precision mode each 32-bit input word holds two independent 16-bit operands with 1 sign, 5 exponent and 10 fraction bits. Lane 0 sits in bits [15:0] and lane 1 in bits [31:16], and both lane sums come out in the same positions of the result word.

The 24-bit mantissa adder is shared between the modes. It is built as two 12-bit segments. In single-precision mode the carry passes between the segments. In half-precision mode that carry is killed and each segment serves one lane. The 8-bit exponent path serves the single-precision operation or half-precision lane 0, and a separate 5-bit exponent path serves lane 1. Both lanes have their own leading-one detection and renormalization. Rounding is by truncation.

The block is a two-stage pipeline. Stage 1 does exponent compare, alignment and the signed mantissa add. Stage 2 does leading-one detection, renormalization and packing.

Top module: `dual_fp_adder`

## Requirements
- R1: With half_mode_i low, sum_o is the truncated sum of op_a_i and op_b_i taken as single-precision values (sign bit 31, exponent [30:23], fraction [22:0]).
- R2: With half_mode_i high, sum_o[15:0] is the truncated sum of the half-precision values in [15:0], and sum_o[31:16] is the sum of the values in [31:16]. Each lane has sign at its top bit, a 5-bit exponent and a 10-bit fraction.
- R3: In half-precision mode no carry or borrow crosses between the lanes, so each lane's result depends only on that lane's operands.
- R4: The operand with the smaller magnitude is shifted right by the exponent difference, and bits shifted out are dropped. A difference of at least the mantissa width (24 single, 11 half) leaves the larger operand unchanged.
- R5: After an effective subtraction, the leading one of the raw mantissa is moved back to the hidden position and the exponent drops by the same count. For example, 1.125 minus 1.0 gives 0.125, with the exponent lowered by 3.
- R6: A carry out of the mantissa add shifts the mantissa right by one and raises the exponent by one.
- R7: A result exponent at or above the all-ones code gives infinity: all-ones exponent, zero fraction, and the sign of the larger operand. In half-precision mode this applies per lane.
- R8: Inputs with a zero exponent field (zeros and denormals) are treated as zero.
- R9: A result that is exactly zero, or whose exponent would fall to zero or below, is output as +0 (all bits zero in its lane).
- R10: valid_o rises exactly two cycles after valid_i. Back-to-back operations of different modes each produce their own result, because the mode is captured with the operands.
- R11: While rst_ni is low, valid_o and sum_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| half_mode_i | input | 1 | 1: two half-precision lanes, 0: one single-precision add |
| op_a_i | input | 32 | First operand word |
| op_b_i | input | 32 | Second operand word |
| valid_o | output | 1 | sum_o holds a new result |
| sum_o | output | 32 | Result word |

## Verification
The hardest case to reach from the ports is a borrow in lane 0 leaking into lane 1. Every lane-0 subtraction produces a carry out of the low segment, and in half-precision mode that carry must be suppressed. Directed words therefore pair a lane-0 subtraction with a lane-1 addition, and the reverse. A pseudo-random sweep adds more such pairs by drawing exponents close together, fractions that differ in only a few low bits, and random signs, so both cancellation and cross-lane borrows occur often. Deep cancellation, exponent underflow and per-lane overflow are reached by the same biased draws, together with directed maximum-exponent operands.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int SP_EW  = 8;
  localparam int SP_FW  = 23;
  localparam int HP_EW  = 5;
  localparam int HP_FW  = 10;
  localparam int SP_MW  = SP_FW + 1;
  localparam int HP_MW  = HP_FW + 1;
  localparam int SEG_W  = HP_MW + 1;
  localparam int RAW_W  = SP_MW + 1;
  localparam int WORD_W = 1 + SP_EW + SP_FW;

  typedef struct packed {
    logic             fp16;
    logic             sgn0;
    logic [SP_EW-1:0] exp0;
    logic             sgn1;
    logic [HP_EW-1:0] exp1;
    logic [RAW_W-1:0] raw;
  } stage1_t;
endpackage

// File: rtl/fpa_lead_one.sv
module fpa_lead_one #(
  parameter int N  = 24,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  v_i,
  output logic [CW-1:0] pos_o
);
  logic [N-1:0] iso;
  logic         seen;

  // keep only the leftmost set bit
  always_comb begin
    seen = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      iso[i] = v_i[i] & ~seen;
      seen   = seen | v_i[i];
    end
  end

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < N; i++)
      if (iso[i]) pos_o = pos_o | CW'(i);
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int EW = 8,
  parameter int MW = 24
) (
  input  logic          sgn_a_i,
  input  logic [EW-1:0] exp_a_i,
  input  logic [MW-1:0] man_a_i,
  input  logic          sgn_b_i,
  input  logic [EW-1:0] exp_b_i,
  input  logic [MW-1:0] man_b_i,
  output logic          sgn_o,
  output logic          sub_o,
  output logic [EW-1:0] exp_big_o,
  output logic [MW-1:0] man_big_o,
  output logic [MW-1:0] man_sml_o
);
  logic [MW-1:0] ma, mb, sml;
  logic [EW-1:0] exp_sml, diff;
  logic          a_ge;

  // zero exponent field flushes the operand
  assign ma   = (exp_a_i == '0) ? '0 : man_a_i;
  assign mb   = (exp_b_i == '0) ? '0 : man_b_i;
  assign a_ge = {exp_a_i, ma} >= {exp_b_i, mb};

  assign sgn_o     = a_ge ? sgn_a_i : sgn_b_i;
  assign sub_o     = sgn_a_i ^ sgn_b_i;
  assign exp_big_o = a_ge ? exp_a_i : exp_b_i;
  assign exp_sml   = a_ge ? exp_b_i : exp_a_i;
  assign man_big_o = a_ge ? ma : mb;
  assign sml       = a_ge ? mb : ma;
  assign diff      = exp_big_o - exp_sml;
  assign man_sml_o = (int'(diff) >= MW) ? '0 : (sml >> diff);
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm #(
  parameter int EW = 8,
  parameter int MW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MW:0]   raw_i,
  input  logic [EW-1:0] exp_i,
  input  logic [EW-1:0] emax_i,
  output logic [EW-1:0] exp_o,
  output logic [MW-2:0] frac_o,
  output logic          zero_o
);
  localparam int CW = $clog2(MW);

  logic [CW-1:0] lead_pos, shamt;
  logic [EW:0]   e_n;
  logic [MW-1:0] m_n;
  logic          under, ovf;

  fpa_lead_one #(.N(MW), .CW(CW)) u_lead (
    .v_i   (raw_i[MW-1:0]),
    .pos_o (lead_pos)
  );

  assign shamt = CW'(MW - 1) - lead_pos;

  always_comb begin
    if (raw_i[MW]) begin
      e_n   = {1'b0, exp_i} + 1'b1;
      m_n   = raw_i[MW:1];
      under = 1'b0;
    end else begin
      m_n   = raw_i[MW-1:0] << shamt;
      e_n   = {1'b0, exp_i} - (EW+1)'(shamt);
      under = {1'b0, exp_i} <= (EW+1)'(shamt);
    end
  end

  assign zero_o = ~(|raw_i) | under;
  assign ovf    = ~zero_o & (e_n >= {1'b0, emax_i});
  assign exp_o  = zero_o ? '0 : (ovf ? emax_i : e_n[EW-1:0]);
  assign frac_o = (zero_o | ovf) ? '0 : m_n[MW-2:0];

  // R5: shifter driven by the leading-one encoder lands on the hidden bit
  assert_hidden_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_i[MW] && (|raw_i)) |-> m_n[MW-1]);

  // R7: exponent never passes the infinity code
  assert_exp_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o <= emax_i);
endmodule

// File: rtl/dual_fp_adder.sv
module dual_fp_adder
  import fpadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              half_mode_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] sum_o
);
  localparam int HP_W = 1 + HP_EW + HP_FW;

  // ---------------- stage 1: align and add ----------------
  logic             fp16;
  logic             l0_sa, l0_sb;
  logic [SP_EW-1:0] l0_ea, l0_eb;
  logic [SP_MW-1:0] l0_ma, l0_mb;

  assign fp16  = half_mode_i;
  assign l0_sa = fp16 ? op_a_i[HP_W-1] : op_a_i[WORD_W-1];
  assign l0_sb = fp16 ? op_b_i[HP_W-1] : op_b_i[WORD_W-1];
  assign l0_ea = fp16 ? SP_EW'(op_a_i[HP_W-2:HP_FW]) : op_a_i[WORD_W-2:SP_FW];
  assign l0_eb = fp16 ? SP_EW'(op_b_i[HP_W-2:HP_FW]) : op_b_i[WORD_W-2:SP_FW];
  assign l0_ma = fp16 ? SP_MW'({1'b1, op_a_i[HP_FW-1:0]}) : {1'b1, op_a_i[SP_FW-1:0]};
  assign l0_mb = fp16 ? SP_MW'({1'b1, op_b_i[HP_FW-1:0]}) : {1'b1, op_b_i[SP_FW-1:0]};

  logic             l0_sgn, l0_sub;
  logic [SP_EW-1:0] l0_exp;
  logic [SP_MW-1:0] l0_big, l0_sml;
  logic             l1_sgn, l1_sub;
  logic [HP_EW-1:0] l1_exp;
  logic [HP_MW-1:0] l1_big, l1_sml;

  fpa_align #(.EW(SP_EW), .MW(SP_MW)) u_align0 (
    .sgn_a_i (l0_sa), .exp_a_i (l0_ea), .man_a_i (l0_ma),
    .sgn_b_i (l0_sb), .exp_b_i (l0_eb), .man_b_i (l0_mb),
    .sgn_o (l0_sgn), .sub_o (l0_sub), .exp_big_o (l0_exp),
    .man_big_o (l0_big), .man_sml_o (l0_sml)
  );

  fpa_align #(.EW(HP_EW), .MW(HP_MW)) u_align1 (
    .sgn_a_i (op_a_i[WORD_W-1]), .exp_a_i (op_a_i[WORD_W-2 -: HP_EW]),
    .man_a_i ({1'b1, op_a_i[HP_W +: HP_FW]}),
    .sgn_b_i (op_b_i[WORD_W-1]), .exp_b_i (op_b_i[WORD_W-2 -: HP_EW]),
    .man_b_i ({1'b1, op_b_i[HP_W +: HP_FW]}),
    .sgn_o (l1_sgn), .sub_o (l1_sub), .exp_big_o (l1_exp),
    .man_big_o (l1_big), .man_sml_o (l1_sml)
  );

  // shared mantissa adder, two segments
  logic [SP_MW-1:0] add_x, add_y, y_eff;
  logic             sub_hi, cin_hi;
  logic [SEG_W:0]   seg_lo, seg_hi;

  assign add_x  = fp16 ? {1'b0, l1_big, 1'b0, l0_big[HP_MW-1:0]} : l0_big;
  assign add_y  = fp16 ? {1'b0, l1_sml, 1'b0, l0_sml[HP_MW-1:0]} : l0_sml;
  assign sub_hi = fp16 ? l1_sub : l0_sub;
  assign y_eff  = {sub_hi ? ~add_y[2*SEG_W-1:SEG_W] : add_y[2*SEG_W-1:SEG_W],
                   l0_sub ? ~add_y[SEG_W-1:0]       : add_y[SEG_W-1:0]};

  assign seg_lo = {1'b0, add_x[SEG_W-1:0]} + {1'b0, y_eff[SEG_W-1:0]} + (SEG_W+1)'(l0_sub);
  assign cin_hi = fp16 ? sub_hi : seg_lo[SEG_W];  // segment carry cut in half mode
  assign seg_hi = {1'b0, add_x[2*SEG_W-1:SEG_W]} + {1'b0, y_eff[2*SEG_W-1:SEG_W]}
                + (SEG_W+1)'(cin_hi);

  stage1_t s1_d, s1_q;
  logic    s1_valid_q;

  assign s1_d.fp16 = fp16;
  assign s1_d.sgn0 = l0_sgn;
  assign s1_d.exp0 = l0_exp;
  assign s1_d.sgn1 = l1_sgn;
  assign s1_d.exp1 = l1_exp;
  assign s1_d.raw  = {seg_hi[SEG_W] & ~l0_sub, seg_hi[SEG_W-1:0], seg_lo[SEG_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q       <= '0;
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) s1_q <= s1_d;
    end
  end

  // ---------------- stage 2: renormalize and pack ----------------
  logic [RAW_W-1:0] n0_raw;
  logic [SP_EW-1:0] n0_emax, n0_exp;
  logic [SP_FW-1:0] n0_frac;
  logic             n0_zero;
  logic [HP_EW-1:0] n1_exp;
  logic [HP_FW-1:0] n1_frac;
  logic             n1_zero;

  assign n0_raw  = s1_q.fp16 ? {s1_q.raw[SEG_W-1:0], (RAW_W-SEG_W)'(0)} : s1_q.raw;
  assign n0_emax = s1_q.fp16 ? SP_EW'((1 << HP_EW) - 1) : '1;

  fpa_norm #(.EW(SP_EW), .MW(SP_MW)) u_norm0 (
    .clk_i, .rst_ni,
    .raw_i (n0_raw), .exp_i (s1_q.exp0), .emax_i (n0_emax),
    .exp_o (n0_exp), .frac_o (n0_frac), .zero_o (n0_zero)
  );

  fpa_norm #(.EW(HP_EW), .MW(HP_MW)) u_norm1 (
    .clk_i, .rst_ni,
    .raw_i (s1_q.raw[2*SEG_W-1:SEG_W]), .exp_i (s1_q.exp1), .emax_i ('1),
    .exp_o (n1_exp), .frac_o (n1_frac), .zero_o (n1_zero)
  );

  logic [WORD_W-1:0] sum_d;

  assign sum_d = s1_q.fp16
    ? {s1_q.sgn1 & ~n1_zero, n1_exp, n1_frac,
       s1_q.sgn0 & ~n0_zero, n0_exp[HP_EW-1:0], n0_frac[SP_FW-1 -: HP_FW]}
    : {s1_q.sgn0 & ~n0_zero, n0_exp, n0_frac};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= s1_valid_q;
      if (s1_valid_q) sum_o <= sum_d;
    end
  end

  // R3: upper segment equals lane 1's own sum, untouched by lane 0
  assert_lane_isolation_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && half_mode_i) |->
      (seg_hi[SEG_W-1:0] == (l1_sub ? ({1'b0, l1_big} - {1'b0, l1_sml})
                                    : ({1'b0, l1_big} + {1'b0, l1_sml}))));

  assert_stage1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_valid_q);

  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |=> valid_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_q |=> !valid_o);

  // R9: zero results never carry a negative sign
  assert_pos_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (sum_o[WORD_W-2:0] == '0)) |-> !sum_o[WORD_W-1]);
endmodule

// File: tb/dual_fp_adder_test.sv
`timescale 1ns/1ps
module dual_fp_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic        half_mode = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        valid_out;
  logic [31:0] sum_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_fp_adder uut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_in), .half_mode_i (half_mode),
    .op_a_i (op_a), .op_b_i (op_b), .valid_o (valid_out), .sum_o (sum_out)
  );

  function automatic logic [31:0] ref_add(longint a, longint b, int ew, int fw);
    longint emax = (longint'(1) << ew) - 1;
    longint fmask = (longint'(1) << fw) - 1;
    longint ea = (a >> fw) & emax, eb = (b >> fw) & emax;
    longint sa = (a >> (ew + fw)) & 1, sb = (b >> (ew + fw)) & 1;
    longint ma = (ea == 0) ? 0 : ((longint'(1) << fw) | (a & fmask));
    longint mb = (eb == 0) ? 0 : ((longint'(1) << fw) | (b & fmask));
    longint eL, eS, mL, mS, sL, sS, d, r, e;
    if (eb > ea || (eb == ea && mb > ma)) begin
      eL = eb; mL = mb; sL = sb; eS = ea; mS = ma; sS = sa;
    end else begin
      eL = ea; mL = ma; sL = sa; eS = eb; mS = mb; sS = sb;
    end
    d = eL - eS;
    if (d > fw) mS = 0; else mS = mS >> d;
    r = (sL == sS) ? mL + mS : mL - mS;
    e = eL;
    if (r == 0) return '0;
    if (r >= (longint'(1) << (fw + 1))) begin
      r = r >> 1; e = e + 1;
    end else begin
      while (r < (longint'(1) << fw)) begin r = r << 1; e = e - 1; end
    end
    if (e <= 0) return '0;
    if (e >= emax) return 32'((sL << (ew + fw)) | (emax << fw));
    return 32'((sL << (ew + fw)) | (e << fw) | (r & fmask));
  endfunction

  function automatic logic [31:0] expect_of(bit hm, logic [31:0] a, logic [31:0] b);
    if (!hm) return ref_add(longint'(a), longint'(b), 8, 23);
    return {ref_add(longint'(a[31:16]), longint'(b[31:16]), 5, 10)[15:0],
            ref_add(longint'(a[15:0]),  longint'(b[15:0]),  5, 10)[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one operation: issue, then sample after the second rising edge
  task automatic run_op(string req, bit hm, logic [31:0] a, logic [31:0] b);
    logic [31:0] exp = expect_of(hm, a, b);
    @(negedge clk);
    valid_in = 1'b1; half_mode = hm; op_a = a; op_b = b;
    @(negedge clk);
    valid_in = 1'b0;
    @(negedge clk);
    chk(req, {31'b0, valid_out}, 32'd1);
    chk(req, sum_out, exp);
  endtask

  function automatic int clip(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic pick_pair(int emax_fin, int fw, output logic [31:0] a, output logic [31:0] b);
    int ea, eb, sel;
    logic [31:0] fa, fb, fmask;
    fmask = (32'd1 << fw) - 1;
    ea  = int'($urandom_range(emax_fin, 1));
    sel = int'($urandom_range(4, 0));
    case (sel)
      0: eb = ea;
      1: eb = clip(ea + int'($urandom_range(6, 0)) - 3, 0, emax_fin);
      2: eb = int'($urandom_range(emax_fin, 0));
      3: eb = clip(ea - fw - 1 - int'($urandom_range(3, 0)), 0, emax_fin);
      default: eb = 0;
    endcase
    fa = $urandom() & fmask;
    fb = $urandom_range(1, 0) ? (fa ^ ($urandom() & 32'hF)) & fmask : $urandom() & fmask;
    a = (32'($urandom_range(1, 0)) << (fw + $clog2(emax_fin + 2))) | (32'(ea) << fw) | fa;
    b = (32'($urandom_range(1, 0)) << (fw + $clog2(emax_fin + 2))) | (32'(eb) << fw) | fb;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, e1, e2;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {31'b0, valid_out}, 32'd0);
    chk("R11 reset sum", sum_out, 32'd0);
    rst_n = 1'b1;

    // single precision directed
    run_op("R1 1+1", 1'b0, 32'h3F800000, 32'h3F800000);
    chk("R6 carry renorm", sum_out, 32'h40000000);
    run_op("R1 1.5+2.25", 1'b0, 32'h3FC00000, 32'h40100000);
    run_op("R5 1.125-1.0", 1'b0, 32'h3F900000, 32'hBF800000);
    chk("R5 exponent drop 3", sum_out, 32'h3E000000);
    run_op("R9 exact cancel", 1'b0, 32'h3F800000, 32'hBF800000);
    chk("R9 plus zero", sum_out, 32'h00000000);
    run_op("R4 diff 23", 1'b0, 32'h3F800000, 32'h34000000);
    chk("R4 diff 23 value", sum_out, 32'h3F800001);
    run_op("R4 diff 24 shifted out", 1'b0, 32'h3F800000, 32'h33C00000);
    chk("R4 diff 24 value", sum_out, 32'h3F800000);
    run_op("R4 diff 30", 1'b0, 32'hBF800000, 32'h30800000);
    chk("R4 diff 30 value", sum_out, 32'hBF800000);
    run_op("R8 denormal operand", 1'b0, 32'h3F800000, 32'h00000001);
    chk("R8 denormal flushed", sum_out, 32'h3F800000);
    run_op("R8 two denormals", 1'b0, 32'h00400000, 32'h80400000);
    chk("R8 zero result", sum_out, 32'h00000000);
    run_op("R7 overflow pos", 1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF);
    chk("R7 +inf", sum_out, 32'h7F800000);
    run_op("R7 overflow neg", 1'b0, 32'hFF7FFFFF, 32'hFF000000);
    chk("R7 -inf", sum_out, 32'hFF800000);
    run_op("R9 underflow", 1'b0, 32'h00800001, 32'h80800000);
    chk("R9 underflow zero", sum_out, 32'h00000000);

    // half precision directed
    run_op("R7 lane0 overflow only", 1'b1, 32'h3C007BFF, 32'h3C007BFF);
    chk("R7 lane split", sum_out, 32'h40007C00);
    run_op("R3 lane0 sub lane1 add", 1'b1, 32'h3C003E00, 32'h3C00BC00);
    chk("R3 no borrow leak", sum_out, 32'h40003800);
    run_op("R3 lane1 sub lane0 add", 1'b1, 32'h3E003C00, 32'hBC003C00);
    chk("R3 no carry leak", sum_out, 32'h38004000);
    run_op("R9 lane1 cancel", 1'b1, 32'h3C004000, 32'hBC004000);
    chk("R9 lane1 zero", sum_out, 32'h00004400);
    run_op("R5 lane1 1001-1000", 1'b1, 32'h3C800000, 32'hBC000000);
    chk("R5 lane1 value", sum_out, 32'h30000000);
    run_op("R4 lane0 diff 11", 1'b1, 32'h00003C00, 32'h00001000);
    chk("R4 lane0 shifted out", sum_out, 32'h00003C00);

    // R10: back-to-back operations of different modes
    e1 = expect_of(1'b0, 32'h40400000, 32'h3F800000);
    e2 = expect_of(1'b1, 32'h40004000, 32'h3C00BC00);
    @(negedge clk);
    valid_in = 1'b1; half_mode = 1'b0; op_a = 32'h40400000; op_b = 32'h3F800000;
    @(negedge clk);
    half_mode = 1'b1; op_a = 32'h40004000; op_b = 32'h3C00BC00;
    chk("R10 not early", {31'b0, valid_out}, 32'd0);
    @(negedge clk);
    valid_in = 1'b0; half_mode = 1'b0;
    chk("R10 first valid", {31'b0, valid_out}, 32'd1);
    chk("R10 first result", sum_out, e1);
    @(negedge clk);
    chk("R10 second valid", {31'b0, valid_out}, 32'd1);
    chk("R10 second result", sum_out, e2);
    @(negedge clk);
    chk("R10 idle", {31'b0, valid_out}, 32'd0);

    // sweeps against arithmetic reference
    for (int i = 0; i < 3000; i++) begin
      pick_pair(254, 23, a, b);
      run_op("R1 sweep", 1'b0, a, b);
    end
    for (int i = 0; i < 3500; i++) begin
      logic [31:0] a0, b0, a1, b1;
      pick_pair(30, 10, a0, b0);
      pick_pair(30, 10, a1, b1);
      run_op("R2 sweep", 1'b1, {a1[15:0], a0[15:0]}, {b1[15:0], b0[15:0]});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule